// File: doc/BRIEF.md
# Dual-Interface Word Memory with Bulk Clear

A parameterized memory of 2^AW words, each DW bits wide, with a combinational read path and writes on the rising clock edge. A static parameter fixes the data interface when the block is built. In shared mode, one data port carries both directions. It is modelled as a write-data bus, a read-data bus and an output-enable. The load input picks between reading and storing. In split mode, a dedicated write-data bus and a store strobe work independently of the read port. Load then only governs whether the read port drives.

A chip-select input turns the whole memory off: no drive and no stores. Several instances can therefore share one external bus. A clear input zeroes every word on each clock edge while it is high. It also forces the read data to zero at once, so the clear appears immediate. The address width may be up to 24 bits and the data width up to 32 bits. The default build is kept small.

Top module: `ram_multi_if`

## Requirements
- R1: After the active-low reset rst_ni is released, every word reads as zero.
- R2: With sel_i=1 and load_i=1, oe_o is 1 and rdata_o shows the word at addr_i in the same cycle, unless clear_i is 1.
- R3: With sel_i=0 or load_i=0, oe_o is 0 and rdata_o is all zeros.
- R4: In shared mode (MODE=IF_SHARED, encoded 0), a rising edge with sel_i=1, load_i=0 and clear_i=0 stores wdata_i at addr_i. store_i has no effect in this mode.
- R5: In split mode (MODE=IF_SPLIT, encoded 1), a rising edge with sel_i=1, store_i=1 and clear_i=0 stores wdata_i at addr_i, whatever the value of load_i.
- R6: With sel_i=0, no edge changes any word.
- R7: While clear_i is 1, rdata_o is zero. Every rising edge with clear_i=1 sets all words to zero, whatever sel_i is, and performs no store.
- R8: When a word is read and written in the same cycle, the read shows the old contents until the clock edge, and the new contents after it.
- R9: In shared mode, an edge with load_i=1 leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; stores and clears happen on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; zeroes the array |
| addr_i | input | AW | Word address for read and write |
| sel_i | input | 1 | Chip select; 0 disables reads and stores |
| load_i | input | 1 | Read request; in shared mode, 0 requests a store |
| store_i | input | 1 | Store strobe; used in split mode only |
| clear_i | input | 1 | Zeroes the whole array and masks the read data |
| wdata_i | input | DW | Write data (shared-port inbound side or dedicated write port) |
| rdata_o | output | DW | Read data; zero when not driving |
| oe_o | output | 1 | High when the read port drives rdata_o |

## Verification
A corrupted word only becomes visible when that address is read with the port enabled. A lost or misplaced store therefore shows on rdata_o at the first enabled read of the affected address after the edge, and it can stay hidden for a long time if that address is not read. Faults in enable or clear decoding show in the same cycle on oe_o or rdata_o. The bench runs both interface variants side by side against reference arrays. This exposes mode-specific gating errors, such as store_i leaking into shared mode or load_i blocking split-mode stores, on the next read.

// File: rtl/ram_multi_if_pkg.sv
package ram_multi_if_pkg;
  typedef enum logic {
    IF_SHARED = 1'b0,
    IF_SPLIT  = 1'b1
  } if_mode_e;
endpackage

// File: rtl/ram_wr_ctrl.sv
module ram_wr_ctrl
  import ram_multi_if_pkg::*;
#(
  parameter if_mode_e MODE = IF_SHARED
) (
  input  logic sel_i,
  input  logic load_i,
  input  logic store_i,
  input  logic clear_i,
  output logic we_o
);
  localparam logic SPLIT = (MODE == IF_SPLIT);

  // shared mode: load low means store; split mode: dedicated strobe
  always_comb begin
    we_o = sel_i & ~clear_i & (SPLIT ? store_i : ~load_i);
  end
endmodule

// File: rtl/ram_array.sv
module ram_array #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rword_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rword_o = mem_q[addr_i];
endmodule

// File: rtl/ram_rd_path.sv
module ram_rd_path #(
  parameter int unsigned DW = 8
) (
  input  logic          sel_i,
  input  logic          load_i,
  input  logic          clear_i,
  input  logic [DW-1:0] rword_i,
  output logic          oe_o,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    oe_o    = sel_i & load_i;
    rdata_o = (oe_o && !clear_i) ? rword_i : '0;
  end
endmodule

// File: rtl/ram_multi_if.sv
module ram_multi_if
  import ram_multi_if_pkg::*;
#(
  parameter int unsigned AW   = 4,
  parameter int unsigned DW   = 8,
  parameter if_mode_e    MODE = IF_SHARED
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          sel_i,
  input  logic          load_i,
  input  logic          store_i,
  input  logic          clear_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          oe_o
);
  logic          we;
  logic [DW-1:0] rword;

  ram_wr_ctrl #(.MODE(MODE)) u_wr_ctrl (
    .sel_i   (sel_i),
    .load_i  (load_i),
    .store_i (store_i),
    .clear_i (clear_i),
    .we_o    (we)
  );

  ram_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .we_i    (we),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rword_o (rword)
  );

  ram_rd_path #(.DW(DW)) u_rd_path (
    .sel_i   (sel_i),
    .load_i  (load_i),
    .clear_i (clear_i),
    .rword_i (rword),
    .oe_o    (oe_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/ram_multi_if_chk.sv
module ram_multi_if_chk
  import ram_multi_if_pkg::*;
#(
  parameter int unsigned AW   = 4,
  parameter int unsigned DW   = 8,
  parameter if_mode_e    MODE = IF_SHARED
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          sel_i,
  input logic          load_i,
  input logic          store_i,
  input logic          clear_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          oe_o
);
  localparam logic SPLIT = (MODE == IF_SPLIT);

  assert_deselect_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (!oe_o && rdata_o == '0));

  assert_noload_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |-> (!oe_o && rdata_o == '0));

  assert_clear_masks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> rdata_o == '0);

  assert_clear_zeroes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> rdata_o == '0);

  assert_shared_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SPLIT && $past(rst_ni) && $past(sel_i && !load_i && !clear_i)
     && oe_o && !clear_i && addr_i == $past(addr_i))
    |-> rdata_o == $past(wdata_i));

  assert_split_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SPLIT && $past(rst_ni) && $past(sel_i && store_i && !clear_i)
     && oe_o && !clear_i && addr_i == $past(addr_i))
    |-> rdata_o == $past(wdata_i));

  assert_load_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SPLIT && $past(rst_ni) && $past(oe_o) && $past(!clear_i)
     && oe_o && !clear_i && addr_i == $past(addr_i))
    |-> rdata_o == $past(rdata_o));
endmodule

bind ram_multi_if ram_multi_if_chk #(.AW(AW), .DW(DW), .MODE(MODE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .sel_i   (sel_i),
  .load_i  (load_i),
  .store_i (store_i),
  .clear_i (clear_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .oe_o    (oe_o)
);

// File: tb/ram_multi_if_bench.sv
`timescale 1ns/1ps
module ram_multi_if_bench;
  import ram_multi_if_pkg::*;

  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int NVEC = 12;
  // vector: [15] sel, [14] load, [13] store, [12] clear, [11:8] addr, [7:0] data
  localparam logic [15:0] VEC [NVEC] = '{
    16'hA211, 16'hC200, 16'h8722, 16'hC700, 16'hE933, 16'hC900,
    16'h2244, 16'hC200, 16'hB455, 16'hC200, 16'hAF66, 16'hCF00
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  // undriven controls count as active: default-high pulls
  logic sel = 1'b1, load = 1'b1, store = 1'b1, clear = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_sh, rd_sp;
  logic oe_sh, oe_sp;

  logic [DW-1:0] ref_sh [DEPTH];
  logic [DW-1:0] ref_sp [DEPTH];
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ram_multi_if #(.AW(AW), .DW(DW), .MODE(IF_SHARED)) u_ram_multi_if (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sel_i(sel), .load_i(load),
    .store_i(store), .clear_i(clear), .wdata_i(wdata), .rdata_o(rd_sh), .oe_o(oe_sh)
  );

  ram_multi_if #(.AW(AW), .DW(DW), .MODE(IF_SPLIT)) u_ram_multi_if_split (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sel_i(sel), .load_i(load),
    .store_i(store), .clear_i(clear), .wdata_i(wdata), .rdata_o(rd_sp), .oe_o(oe_sp)
  );

  task automatic chk(input string tag, input string who, input logic oe_a, input logic oe_e,
                     input logic [DW-1:0] rd_a, input logic [DW-1:0] rd_e);
    checks++;
    if (oe_a !== oe_e || rd_a !== rd_e) begin
      failures++;
      $display("FAIL %s %s addr=%0d: oe=%b rdata=%h expected oe=%b rdata=%h",
               tag, who, addr, oe_a, rd_a, oe_e, rd_e);
    end
  endtask

  // drive after negedge, check combinational read, clock, update references
  task automatic step(input string tag_in, input logic s, input logic l, input logic st,
                      input logic c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    string tag;
    logic oe_e;
    sel = s; load = l; store = st; clear = c; addr = a; wdata = d;
    #1;
    oe_e = s & l;
    if (tag_in != "") tag = tag_in;
    else if (!oe_e) tag = "R3";
    else if (c) tag = "R7";
    else tag = "R2";
    chk(tag, "shared", oe_sh, oe_e, rd_sh, (oe_e && !c) ? ref_sh[a] : '0);
    chk(tag, "split",  oe_sp, oe_e, rd_sp, (oe_e && !c) ? ref_sp[a] : '0);
    @(posedge clk);
    if (c) begin
      for (int i = 0; i < DEPTH; i++) begin ref_sh[i] = '0; ref_sp[i] = '0; end
    end else begin
      if (s && !l) ref_sh[a] = d;   // R4
      if (s && st) ref_sp[a] = d;   // R5
    end
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin ref_sh[i] = '0; ref_sp[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state of every word, with no store in either mode
    for (int i = 0; i < DEPTH; i++) step("R1", 1'b1, 1'b1, 1'b0, 1'b0, AW'(i), 8'hFF);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      step("", VEC[v][15], VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11:8], VEC[v][7:0]);
    end

    // R4: shared store with store_i low; split must not store
    step("R4", 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 8'hA5);
    step("R4", 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 8'h00);
    // R5 / R9: split stores with load high; shared must not
    step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 4'd6, 8'h5A);
    step("R9", 1'b1, 1'b1, 1'b0, 1'b0, 4'd6, 8'h00);
    // R8: read and write of one word in the same cycle
    step("R8", 1'b1, 1'b1, 1'b1, 1'b0, 4'd6, 8'h3C);
    step("R8", 1'b1, 1'b1, 1'b0, 1'b0, 4'd6, 8'h00);
    // R6: deselected store attempts
    step("R6", 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 8'hEE);
    step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 8'h00);
    // R7: clear while deselected and while storing; then read back
    step("R7", 1'b0, 1'b0, 1'b1, 1'b1, 4'd6, 8'h77);
    step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 4'd6, 8'h00);
    step("R7", 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 8'h99);
    step("R7", 1'b1, 1'b1, 1'b1, 1'b1, 4'd1, 8'h12);
    step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 8'h00);

    // random mix in both modes
    for (int n = 0; n < 400; n++) begin
      step("", ($urandom % 8) != 0, $urandom % 2 == 1, $urandom % 2 == 1,
           ($urandom % 25) == 0, AW'($urandom), DW'($urandom));
    end

    // R3: each form of disabled read
    step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 8'h00);
    step("R3", 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule